// File: doc/BRIEF.md
# Double-Buffered 10-Bit Pulse-Width Modulator

This block generates a single pulse-width modulated output from an 8-bit period timer. Two extra fractional bits, taken from a free-running sub-step counter, extend the timer to a 10-bit count. The duty value is compared against this count. Software loads a pending duty value (an 8-bit upper part and a 2-bit lower part), the period, and a small control field through one synchronous register write port. The prescale ratio can be 1, 4 or 16.

The pending duty value is copied into an active copy only at the end of a period, so a write never truncates or stretches the pulse in progress. The active value can be read at all times on a dedicated output. When the generator is switched on, it first runs one full period with its output low. It does this because nothing has been latched yet. Output pulses begin after the first period boundary.

The effective resolution is log2(4 × (period + 1)) bits. A period of 0xFF gives 10 bits, 0x3F gives 8 bits and 0x1F gives 7 bits.

Top module: `pwm10_dbuf`

## Requirements
- R1: Reset is synchronous and active high. It drives `pwm_out` low and `duty_active` to 0, sets the period register to 0xFF, stops the generator and selects prescale 1.
- R2: A write happens on a rising clock edge while `wr_en` is high. Address 0 loads pending duty bits 9:2 from `wr_data[7:0]`. Address 1 loads pending duty bits 1:0 from `wr_data[1:0]`. Address 2 loads the period. Address 3 loads the control field: bit 0 is run, and bits 2:1 are the prescale select.
- R3: `duty_active` changes only in the first cycle of a new period. It then takes the pending duty value held in the last cycle of the previous period. Duty writes made during a period do not affect that period.
- R4: The 10-bit count is {timer, fractional bits}. It is 0 in the first cycle of every period. `pwm_out` is high from the period start for as long as the count is below the active duty value. It is low from the cycle in which the count equals that value. At prescale 1 the output is therefore high for exactly D clocks.
- R5: A period lasts (P + 1) × 4 × ps clocks, where P is the period register and ps is the prescale ratio.
- R6: Prescale select 0 gives a ratio of 1, select 1 gives 4, and select 2 or 3 gives 16. The fractional bits advance once every ps clocks, so the high time is D × ps clocks.
- R7: An active duty value of 0 keeps `pwm_out` low for the whole period.
- R8: An active duty value of 4 × (P + 1) or more is never reached by the count, so `pwm_out` stays high for the whole period.
- R9: After run is set, the count starts at 0 in the next cycle and the first period is low throughout. `pwm_out` is low from the first cycle in which run is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated output |
| duty_active | output | 10 | Active (latched) duty value |

## Verification
A corrupted count or a wrong fractional tap shows up at the ports as a misplaced falling edge of `pwm_out` within the same period. A wrong period terminal count shows up as a rising edge that comes early or late, at the very next boundary. A shadow that loads at the wrong moment shows on `duty_active` at once: it either changes mid-period or fails to change at a boundary. The next pulse width then shows the same fault. Each period is therefore compared as a unit, on the full output waveform and on the readback.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  // Register selects on the write port
  typedef enum logic [1:0] {
    REG_DUTY_HI = 2'd0,
    REG_DUTY_LO = 2'd1,
    REG_PERIOD  = 2'd2,
    REG_CTRL    = 2'd3
  } reg_sel_e;

  // Bit positions inside the control register
  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_PS_LSB  = 1;

  // log2 of the prescale ratio for a select code: 0 -> 1, 1 -> 4, else 16
  function automatic int unsigned presc_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Clocks in one period for a given period value and prescale shift
  function automatic int unsigned period_clocks(input int unsigned per,
                                                input int unsigned frac_w,
                                                input int unsigned shift);
    return (per + 1) << (frac_w + shift);
  endfunction

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned FRAC_W = 2,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned DW    = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  output logic [DW-1:0]     pend_duty,
  output logic [TMR_W-1:0]  period,
  output logic              run,
  output logic [1:0]        presc_sel
);

  logic [TMR_W-1:0]  pend_hi_q;
  logic [FRAC_W-1:0] pend_lo_q;
  logic [TMR_W-1:0]  period_q;
  logic              run_q;
  logic [1:0]        sel_q;

  // Decoded write strobes, one per register
  logic wr_hi, wr_lo, wr_per, wr_ctl;
  assign wr_hi  = wr_en && (wr_addr == ADDR_W'(REG_DUTY_HI));
  assign wr_lo  = wr_en && (wr_addr == ADDR_W'(REG_DUTY_LO));
  assign wr_per = wr_en && (wr_addr == ADDR_W'(REG_PERIOD));
  assign wr_ctl = wr_en && (wr_addr == ADDR_W'(REG_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_hi_q <= '0;
      pend_lo_q <= '0;
      period_q  <= '1;
      run_q     <= 1'b0;
      sel_q     <= 2'd0;
    end else begin
      if (wr_hi)  pend_hi_q <= wr_data;
      if (wr_lo)  pend_lo_q <= wr_data[FRAC_W-1:0];
      if (wr_per) period_q  <= wr_data;
      if (wr_ctl) begin
        run_q <= wr_data[CTRL_RUN_BIT];
        sel_q <= wr_data[CTRL_PS_LSB +: 2];
      end
    end
  end

  assign pend_duty = {pend_hi_q, pend_lo_q};
  assign period    = period_q;
  assign run       = run_q;
  assign presc_sel = sel_q;

  // R2: a period write lands on the next edge
  a_r2_period_write: assert property (@(posedge clk) disable iff (rst)
    wr_per |=> (period == $past(wr_data)));

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
  import pwm10_pkg::*;
#(
  parameter int unsigned TMR_W      = 8,
  parameter int unsigned FRAC_W     = 2,
  parameter int unsigned PS_LOG_MAX = 4,
  localparam int unsigned DW        = TMR_W + FRAC_W,
  localparam int unsigned SUB_W     = FRAC_W + PS_LOG_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [1:0]       presc_sel,
  input  logic [TMR_W-1:0] period,
  output logic [DW-1:0]    count,
  output logic             period_end
);

  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] sub_term;
  logic [SUB_W-1:0] sub_shr;
  logic [TMR_W-1:0] tmr_q;
  logic             tick_last;
  logic             tmr_match;
  int unsigned      shift;

  // Sub-step counter spans 4*ps clocks; its top FRAC_W active bits form the fraction
  always_comb begin
    shift    = presc_shift(presc_sel);
    sub_term = SUB_W'((1 << (FRAC_W + shift)) - 1);
    sub_shr  = sub_q >> shift;
  end

  assign tick_last  = (sub_q >= sub_term);
  assign tmr_match  = (tmr_q == period);
  assign period_end = run && tick_last && tmr_match;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sub_q <= '0;
      tmr_q <= '0;
    end else if (tick_last) begin
      sub_q <= '0;
      tmr_q <= tmr_match ? '0 : tmr_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign count = {tmr_q, sub_shr[FRAC_W-1:0]};

  // R5: after the last cycle of a period the count restarts at zero
  a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (count == '0));

  // R9: a stopped generator holds its count at zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == '0));

endmodule

// File: rtl/pwm10_compare.sv
module pwm10_compare #(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          period_end,
  input  logic [DW-1:0] pend_duty,
  input  logic [DW-1:0] count,
  output logic [DW-1:0] shadow,
  output logic          pwm_out
);

  logic [DW-1:0] shadow_q;
  logic          out_q;
  logic          hit;
  logic          pend_nonzero;

  assign hit          = (count == shadow_q);
  assign pend_nonzero = (pend_duty != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      out_q    <= 1'b0;
    end else begin
      if (period_end) shadow_q <= pend_duty;
      if (!run)            out_q <= 1'b0;
      else if (period_end) out_q <= pend_nonzero;
      else if (hit)        out_q <= 1'b0;
    end
  end

  assign shadow  = shadow_q;
  assign pwm_out = run && out_q && !hit;

  // R3: the shadow holds between boundaries
  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(shadow));

  // R3: at a boundary the shadow takes the pending value
  a_r3_shadow_load: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (shadow == $past(pend_duty)));

  // R7: a zero duty never drives the output high
  a_r7_zero_low: assert property (@(posedge clk) disable iff (rst)
    (shadow == '0) |-> !pwm_out);

  // R4: the output rises only at the start of a period
  a_r4_rise_at_start: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> $past(period_end));

endmodule

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf #(
  parameter int unsigned TMR_W      = 8,
  parameter int unsigned FRAC_W     = 2,
  parameter int unsigned PS_LOG_MAX = 4,
  parameter int unsigned ADDR_W     = 2,
  localparam int unsigned DW        = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  output logic              pwm_out,
  output logic [DW-1:0]     duty_active
);

  logic [DW-1:0]    pend_duty;
  logic [TMR_W-1:0] period;
  logic             run;
  logic [1:0]       presc_sel;
  logic [DW-1:0]    count;
  logic             period_end;

  pwm10_regs #(.TMR_W(TMR_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .pend_duty (pend_duty),
    .period    (period),
    .run       (run),
    .presc_sel (presc_sel)
  );

  pwm10_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W), .PS_LOG_MAX(PS_LOG_MAX)) u_tb (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .presc_sel  (presc_sel),
    .period     (period),
    .count      (count),
    .period_end (period_end)
  );

  pwm10_compare #(.DW(DW)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .period_end (period_end),
    .pend_duty  (pend_duty),
    .count      (count),
    .shadow     (duty_active),
    .pwm_out    (pwm_out)
  );

  // R9: the first cycle without run is already low
  a_r9_stop_low: assert property (@(posedge clk) disable iff (rst)
    (run && wr_en && (wr_addr == ADDR_W'(3)) && !wr_data[0]) |=> !pwm_out);

endmodule

// File: tb/pwm10_dbuf_tb_top.sv
module pwm10_dbuf_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_out;
  logic [9:0] duty_active;

  always #10 clk = ~clk;

  pwm10_dbuf dut_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .pwm_out     (pwm_out),
    .duty_active (duty_active)
  );

  typedef struct {
    int    duty;
    int    hi;
    int    len;
    string tag;
  } per_t;

  per_t exp_q[$];

  // Driver-side bookkeeping
  int drv_tests = 0, drv_fail = 0;
  int go_cnt = 0;
  int cur_shadow = 0, pend = 0, per_reg = 255, sel = 0;
  bit finished = 1'b0;

  // Monitor-side bookkeeping
  int   mon_tests = 0, mon_fail = 0, done_cnt = 0;
  int   idx = 0, bad = 0, bad_cyc = 0;
  logic exp_o, bad_act_o, bad_exp_o;
  int   bad_act_s;
  per_t cur;

  // Monitor: checks a whole period per scoreboard item
  always @(negedge clk) begin
    if (done_cnt != go_cnt) begin
      if (idx == 0) begin
        cur = exp_q.pop_front();
        bad = 0;
      end
      exp_o = (idx < cur.hi);
      if (pwm_out !== exp_o || duty_active !== 10'(cur.duty)) begin
        if (bad == 0) begin
          bad_cyc   = idx;
          bad_act_o = pwm_out;
          bad_exp_o = exp_o;
          bad_act_s = int'(duty_active);
        end
        bad++;
      end
      idx++;
      if (idx == cur.len) begin
        mon_tests++;
        if (bad != 0) begin
          mon_fail++;
          $display("FAIL %s: cycle %0d of period: pwm_out=%0b expected %0b, duty_active=%0d expected %0d (%0d bad cycles)",
                   cur.tag, bad_cyc, bad_act_o, bad_exp_o, bad_act_s, cur.duty, bad);
        end
        idx = 0;
        if (exp_q.size() == 0) done_cnt++;
      end
    end
  end

  function automatic int ps_of(input int s);
    return (s == 0) ? 1 : (s == 1) ? 4 : 16;
  endfunction

  function automatic int len_of();
    return 4 * (per_reg + 1) * ps_of(sel);
  endfunction

  function automatic int hi_of(input int d);
    int span;
    span = 4 * (per_reg + 1);
    return ((d < span) ? d : span) * ps_of(sel);
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    drv_tests++;
    if (act != expv) begin
      drv_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // R2: upper eight duty bits at address 0, lower two at address 1
  task automatic set_duty(input int d);
    wr(0, d >> 2);
    wr(1, d & 3);
    pend = d;
  endtask

  task automatic push(input int d, input int hi, input string tag);
    per_t it;
    it.duty = d; it.hi = hi; it.len = len_of(); it.tag = tag;
    exp_q.push_back(it);
  endtask

  // R2: control bit 0 = run, bits 2:1 = prescale select
  task automatic start_run();
    wr(3, (sel << 1) | 1);
    go_cnt++;
  endtask

  task automatic stop_run(input string tag);
    wait (done_cnt == go_cnt);
    wr(3, sel << 1);
    @(negedge clk);
    check({tag, " R9 low once stopped"}, int'(pwm_out), 0);
    check({tag, " R3 readback after run"}, int'(duty_active), pend);
    cur_shadow = pend;
  endtask

  // R9: first period after enabling is low; later ones use the pending duty
  task automatic run_periods(input int nper, input string tag);
    push(cur_shadow, 0, {tag, " R9 first period"});
    for (int k = 0; k < nper; k++) push(pend, hi_of(pend), tag);
    start_run();
    stop_run(tag);
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", drv_tests + mon_tests, drv_fail + mon_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 pwm_out after reset", int'(pwm_out), 0);
    check("R1 duty_active after reset", int'(duty_active), 0);

    // R1 R5: default period 0xFF at prescale 1 -> 1024 clocks, D=512
    set_duty(512);
    run_periods(1, "R1 R5 default period");

    // R2 R4: period 7, duty 13 -> 13 high clocks of 32
    wr(2, 7); per_reg = 7;
    set_duty(13);
    run_periods(2, "R2 R4 duty 13");

    set_duty(31);
    run_periods(1, "R4 duty one below range");

    set_duty(0);
    run_periods(1, "R7 zero duty");

    set_duty(32);
    run_periods(1, "R8 duty equal to range");

    set_duty(33);
    run_periods(1, "R8 duty above range");

    // R3: duty rewritten in the middle of a period
    set_duty(20);
    push(cur_shadow, 0, "R3 first period");
    push(20, 20, "R3 mid-period write ignored");
    push(9, 9, "R3 new value after boundary");
    start_run();
    repeat (38) @(posedge clk);
    set_duty(9);
    stop_run("R3 mid-period");

    // R6: prescale 4, period 3, duty 5 -> 20 high of 64
    sel = 1; wr(2, 3); per_reg = 3;
    set_duty(5);
    run_periods(2, "R6 prescale 4");

    // R6: prescale 16, period 1, duty 3 -> 48 high of 128
    sel = 2; wr(2, 1); per_reg = 1;
    set_duty(3);
    run_periods(1, "R6 prescale 16");

    // R6: select 3 also divides by 16
    sel = 3;
    set_duty(6);
    run_periods(1, "R6 select 3");

    finished = 1'b1;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: run not complete, cycles=200000 expected fewer");
      $display("[TB] %0d tests run, %0d failed", drv_tests + mon_tests + 1, drv_fail + mon_fail + 1);
      $finish;
    end
  end

endmodule